// File: doc/BRIEF.md
# Configurable Vector Operand Pre-Processing Stage

This block sits in front of a SIMD arithmetic core and reshapes one operand vector of complex elements in the same instruction that the core consumes it. Each output lane can take any input lane (shuffle) or every lane can take one chosen input lane (broadcast). Selected lanes can then be forced to zero, which builds the triangular and diagonal access patterns that matrix work needs. Last, each lane can have its components replaced by their absolute values, be conjugated and be negated, all with saturation.

The datapath setting is not carried by the instruction. A local table of 16 setting words is loaded in advance through a write port, and each instruction gives only a table index. A setting that many instructions reuse therefore costs only an index, and one entry can be rewritten without touching the others.

The stage uses a two-state sequencer. `ST_IDLE` means no result is on the output. `ST_EMIT` means the output register holds the result of the instruction taken at the last edge. The transitions are: `ST_IDLE` to `ST_EMIT` when `op_valid` is high; `ST_EMIT` to `ST_EMIT` when `op_valid` is high again; `ST_EMIT` to `ST_IDLE` when `op_valid` is low; `ST_IDLE` to `ST_IDLE` otherwise. Reset enters `ST_IDLE`.

Top module: `vpp_stage`

## Requirements
- R1: A setting word is 27 bits. Bits [3:0] are the per-lane absolute flags and [7:4] the negate flags. Bits [11:8] are the conjugate flags and [15:12] the zero flags, with bit k of each group belonging to lane k. Bits [17+2k:16+2k] give the source lane of output lane k. Bits [25:24] give the broadcast source and bit 26 the broadcast enable. Reset clears all 16 table entries to zero.
- R2: `res_valid` is high in exactly the cycle after each edge with `op_valid` high. `res_vec` changes only after an edge where `op_valid` is high, and otherwise holds its value.
- R3: With broadcast disabled, output lane k starts from input lane sel[k], and any permutation or repetition of lanes is allowed.
- R4: With broadcast enabled, every output lane starts from the input lane named by the broadcast source, and the per-lane selects are ignored.
- R5: A lane whose zero flag is set outputs zero in both components. The zero flag is applied after lane selection.
- R6: A lane whose absolute flag is set has the absolute value of each of its real and imaginary components taken.
- R7: A lane whose conjugate flag is set has its imaginary component negated.
- R8: A lane whose negate flag is set has both components negated.
- R9: Within a lane the operations run in a fixed order: selection, then zeroing, then absolute value, then conjugation, then negation. Negating the most negative 16-bit value, or taking its absolute value, gives the largest positive value (32767).
- R10: A table write takes effect from the next instruction that reads that entry. An instruction that reads an entry in the same cycle as that entry is written uses the old word. A write changes no other entry.
- R11: After reset `res_valid` is 0 and `res_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Setting-table write enable |
| cfg_waddr | input | 4 | Table entry to write |
| cfg_wdata | input | 27 | Setting word to store |
| op_valid | input | 1 | Instruction present this cycle |
| op_addr | input | 4 | Table entry used by the instruction |
| op_vec | input | 128 | Operand vector; lane k at [32k+31:32k], imaginary in the upper 16 bits, real in the lower, two's complement |
| res_valid | output | 1 | Result register holds a fresh result |
| res_vec | output | 128 | Transformed vector, same layout as op_vec |

## Verification
Every result is due one edge after its instruction: the operand, the table read and the lane logic all feed one output register. The bench drives inputs on the falling edge, lets one rising edge pass, and compares at the following falling edge against a value it computes from the stated field positions. Table writes are made a cycle ahead of the instruction that uses them, except in the same-cycle case of R10, where the old word's result is expected at that same sampling point. The cycle after an instruction is sampled again with `op_valid` low, to confirm that `res_valid` has dropped and that `res_vec` holds.

// File: rtl/vpp_pkg.sv
package vpp_pkg;
    localparam int LANES     = 4;
    localparam int CW        = 16;
    localparam int CFG_DEPTH = 16;
    localparam int SELW      = $clog2(LANES);
    localparam int CFGW      = 1 + SELW + LANES * SELW + 4 * LANES;

    localparam logic signed [CW-1:0] SMIN = {1'b1, {(CW-1){1'b0}}};
    localparam logic signed [CW-1:0] SMAX = {1'b0, {(CW-1){1'b1}}};

    typedef struct packed {
        logic                       bc_en;
        logic [SELW-1:0]            bc_src;
        logic [LANES-1:0][SELW-1:0] sel;
        logic [LANES-1:0]           zero;
        logic [LANES-1:0]           conj;
        logic [LANES-1:0]           neg;
        logic [LANES-1:0]           absv;
    } vpp_cfg_t;

    typedef enum logic {ST_IDLE, ST_EMIT} vpp_state_e;

    function automatic logic signed [CW-1:0] sat_neg(input logic signed [CW-1:0] x);
        return (x == SMIN) ? SMAX : -x;
    endfunction

    function automatic logic signed [CW-1:0] sat_abs(input logic signed [CW-1:0] x);
        return x[CW-1] ? sat_neg(x) : x;
    endfunction
endpackage

// File: rtl/vpp_cfg_store.sv
module vpp_cfg_store
    import vpp_pkg::*;
#(
    parameter  int DEPTH = CFG_DEPTH,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  vpp_cfg_t      wdata,
    input  logic [AW-1:0] raddr,
    output vpp_cfg_t      rdata
);
    vpp_cfg_t mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/vpp_lane.sv
module vpp_lane
    import vpp_pkg::*;
(
    input  logic [LANES*2*CW-1:0] src_vec,
    input  logic                  bc_en,
    input  logic [SELW-1:0]       bc_src,
    input  logic [SELW-1:0]       sel,
    input  logic                  zero,
    input  logic                  conj,
    input  logic                  neg,
    input  logic                  absv,
    output logic [2*CW-1:0]       elem
);
    logic [SELW-1:0]        pick;
    logic signed [CW-1:0]   re, im;

    always_comb begin
        pick = bc_en ? bc_src : sel;
        re   = src_vec[int'(pick)*2*CW      +: CW];
        im   = src_vec[int'(pick)*2*CW + CW +: CW];
        if (zero) begin
            re = '0;
            im = '0;
        end
        if (absv) begin
            re = sat_abs(re);
            im = sat_abs(im);
        end
        if (conj) begin
            im = sat_neg(im);
        end
        if (neg) begin
            re = sat_neg(re);
            im = sat_neg(im);
        end
        elem = {im, re};
    end
endmodule

// File: rtl/vpp_stage.sv
module vpp_stage
    import vpp_pkg::*;
#(
    parameter  int DEPTH = CFG_DEPTH,
    localparam int AW    = $clog2(DEPTH),
    localparam int VW    = LANES * 2 * CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_waddr,
    input  logic [CFGW-1:0] cfg_wdata,
    input  logic            op_valid,
    input  logic [AW-1:0]   op_addr,
    input  logic [VW-1:0]   op_vec,
    output logic            res_valid,
    output logic [VW-1:0]   res_vec
);
    vpp_state_e      state_q, state_d;
    vpp_cfg_t        cur_cfg;
    logic [VW-1:0]   lane_out;

    vpp_cfg_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .waddr (cfg_waddr),
        .wdata (vpp_cfg_t'(cfg_wdata)),
        .raddr (op_addr),
        .rdata (cur_cfg)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vpp_lane u_lane (
            .src_vec (op_vec),
            .bc_en   (cur_cfg.bc_en),
            .bc_src  (cur_cfg.bc_src),
            .sel     (cur_cfg.sel[g]),
            .zero    (cur_cfg.zero[g]),
            .conj    (cur_cfg.conj[g]),
            .neg     (cur_cfg.neg[g]),
            .absv    (cur_cfg.absv[g]),
            .elem    (lane_out[g*2*CW +: 2*CW])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (op_valid)  state_d = ST_EMIT;
            ST_EMIT: if (!op_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        res_vec <= '0;
        else if (op_valid) res_vec <= lane_out;
    end

    assign res_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/vpp_stage_chk.sv
module vpp_stage_chk
    import vpp_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  op_valid,
    input vpp_cfg_t              cur_cfg,
    input logic                  res_valid,
    input logic [LANES*2*CW-1:0] res_vec
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(res_vec));

    for (genvar l = 0; l < LANES; l++) begin : g_chk
        assert_mask_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && cur_cfg.zero[l]) |=> (res_vec[l*2*CW +: 2*CW] == '0));

        assert_abs_nonneg_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && cur_cfg.absv[l] && !cur_cfg.conj[l] && !cur_cfg.neg[l])
            |=> (!res_vec[l*2*CW + CW - 1] && !res_vec[l*2*CW + 2*CW - 1]));

        assert_no_min_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && (cur_cfg.neg[l] || cur_cfg.absv[l]))
            |=> (res_vec[l*2*CW +: CW] != SMIN));
    end
endmodule

bind vpp_stage vpp_stage_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .cur_cfg   (cur_cfg),
    .res_valid (res_valid),
    .res_vec   (res_vec)
);

// File: tb/vpp_stage_tb.sv
module vpp_stage_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [3:0]   cfg_waddr = '0;
    logic [26:0]  cfg_wdata = '0;
    logic         op_valid = 1'b0;
    logic [3:0]   op_addr = '0;
    logic [127:0] op_vec = '0;
    logic         res_valid;
    logic [127:0] res_vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vpp_stage u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
        .cfg_wdata(cfg_wdata), .op_valid(op_valid), .op_addr(op_addr),
        .op_vec(op_vec), .res_valid(res_valid), .res_vec(res_vec)
    );

    function automatic logic [26:0] mk(input logic be, input logic [1:0] bs,
                                       input logic [7:0] sel, input logic [3:0] z,
                                       input logic [3:0] c, input logic [3:0] n,
                                       input logic [3:0] a);
        return {be, bs, sel, z, c, n, a};
    endfunction

    function automatic logic signed [15:0] mneg(input logic signed [15:0] x);
        if (x == -16'sd32768) return 16'sd32767;
        return -x;
    endfunction

    function automatic logic [127:0] model(input logic [26:0] w, input logic [127:0] v);
        logic [127:0] r;
        for (int k = 0; k < 4; k++) begin
            int src;
            logic signed [15:0] re, im;
            src = w[26] ? int'(w[25:24]) : int'(w[17+2*k -: 2]);
            re = v[src*32 +: 16];
            im = v[src*32 + 16 +: 16];
            if (w[12+k]) begin re = 0; im = 0; end
            if (w[k]) begin
                if (re < 0) re = mneg(re);
                if (im < 0) im = mneg(im);
            end
            if (w[8+k]) im = mneg(im);
            if (w[4+k]) begin re = mneg(re); im = mneg(im); end
            r[k*32 +: 32] = {im, re};
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [26:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // issue at negedge, one rising edge, sample at the next negedge
    task automatic run(input string tag, input logic [3:0] a, input logic [127:0] v,
                       input logic [127:0] exp);
        op_valid = 1'b1; op_addr = a; op_vec = v;
        @(negedge clk);
        chk({tag, " valid"}, {127'd0, res_valid}, 128'd1);
        chk(tag, res_vec, exp);
        op_valid = 1'b0;
    endtask

    task automatic full(input string tag, input logic [3:0] a, input logic [26:0] w,
                        input logic [127:0] v);
        wr(a, w);
        run(tag, a, v, model(w, v));
    endtask

    logic [127:0] vecs [3];

    initial begin
        vecs[0] = {16'hFFE4, 16'd400, 16'hFFEB, 16'd300, 16'hFFF2, 16'd200, 16'hFFF9, 16'd100};
        vecs[1] = {16'hFFFF, 16'h8000, 16'h8000, 16'hFFFB, 16'h8000, 16'h7FFF, 16'h7FFF, 16'h8000};
        vecs[2] = {16'h1234, 16'hEDCC, 16'h8001, 16'h0001, 16'h0000, 16'h7FFE, 16'hC000, 16'h4000};

        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 res_valid", {127'd0, res_valid}, 128'd0);
        chk("R11 res_vec", res_vec, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: cleared entry -> every lane takes lane 0 unchanged
        run("R1 cleared entry", 4'd3, vecs[0], {4{vecs[0][31:0]}});
        // R2: valid drops and result holds
        op_vec = vecs[2];
        @(negedge clk);
        chk("R2 valid low", {127'd0, res_valid}, 128'd0);
        chk("R2 hold", res_vec, {4{vecs[0][31:0]}});

        // R3: every select combination
        for (int s = 0; s < 256; s++)
            full("R3 shuffle", 4'(s % 16), mk(1'b0, 2'd0, 8'(s), 4'h0, 4'h0, 4'h0, 4'h0), vecs[s % 3]);
        // R4: broadcast overrides selects
        for (int b = 0; b < 4; b++)
            for (int j = 0; j < 3; j++)
                full("R4 broadcast", 4'(b + 4), mk(1'b1, 2'(b), 8'h1B, 4'h0, 4'h0, 4'h0, 4'h0), vecs[j]);
        // R5: zero patterns after selection
        for (int z = 0; z < 16; z++)
            full("R5 zero", 4'(z), mk(1'b0, 2'd0, 8'h4E, 4'(z), 4'h0, 4'h0, 4'h0), vecs[z % 3]);
        // R6 R7 R8 R9: flag combinations and saturation
        for (int f = 0; f < 64; f++)
            for (int j = 0; j < 3; j++)
                full("R6 R7 R8 R9 flags", 4'(f % 16),
                     mk(1'b0, 2'd0, 8'hE4, 4'h0, 4'(f), 4'(f >> 2), 4'(f ^ 6'h2D)), vecs[j]);
        // R9: saturation on most negative values
        full("R9 sat abs", 4'd9, mk(1'b0, 2'd0, 8'hE4, 4'h0, 4'h0, 4'h0, 4'hF), vecs[1]);
        full("R9 sat neg", 4'd9, mk(1'b0, 2'd0, 8'hE4, 4'h0, 4'h0, 4'hF, 4'h0), vecs[1]);

        // R10: same-cycle write and read use the old word
        wr(4'd5, mk(1'b0, 2'd0, 8'hE4, 4'h0, 4'h0, 4'h0, 4'h0));
        cfg_we = 1'b1; cfg_waddr = 4'd5; cfg_wdata = mk(1'b1, 2'd2, 8'hE4, 4'h1, 4'h0, 4'h0, 4'h0);
        run("R10 old word", 4'd5, vecs[0], vecs[0]);
        cfg_we = 1'b0;
        run("R10 new word", 4'd5, vecs[0], model(mk(1'b1, 2'd2, 8'hE4, 4'h1, 4'h0, 4'h0, 4'h0), vecs[0]));
        wr(4'd6, mk(1'b0, 2'd0, 8'h00, 4'hF, 4'hF, 4'hF, 4'hF));
        run("R10 neighbour intact", 4'd5, vecs[2], model(mk(1'b1, 2'd2, 8'hE4, 4'h1, 4'h0, 4'h0, 4'h0), vecs[2]));

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule